// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This purely combinational block decides whether a conditional control transfer is taken. It is given a 6-bit operation code and the five arithmetic flags left by an earlier instruction: carry, zero, sign, overflow and parity. It also receives the current value of the 16-bit count register. Flag-based operations need only the flags. Count-based operations test the count register or decrement it. One operation requests the overflow trap instead of taking a branch.

Several operation codes are synonyms of each other, such as "below" and "carry", or "above" and "not below nor equal". A decode stage reduces every code to one canonical condition, so all synonyms share the same evaluation logic. Loop operations form the decremented count first. They then combine the new value with the zero flag and present it on `count_out` with a write enable. The surrounding pipeline performs the register write and redirects fetch; neither is done here. All ports are plain control signals, with no handshake.

Top module: `bcond_eval`

## Requirements
- R1: Code 0 (overflow) is taken when the overflow flag is 1. Code 1 (no overflow) is taken when it is 0.
- R2: Codes 2, 3 and 4 (below, carry, not above nor equal) are taken when carry = 1. Codes 5, 6 and 7 (above or equal, not below, no carry) are taken when carry = 0.
- R3: Codes 8 and 9 (equal, zero) are taken when zero = 1. Codes 10 and 11 (not equal, not zero) are taken when zero = 0.
- R4: Codes 12 and 13 (below or equal, not above) are taken when carry or zero is 1. Codes 14 and 15 (above, not below nor equal) are taken when both are 0.
- R5: Code 16 is taken when sign = 1 and code 17 when sign = 0. Codes 18 and 19 (parity even) are taken when parity = 1. Codes 20 and 21 (parity odd) are taken when parity = 0.
- R6: Codes 22 and 23 (less) are taken when sign differs from overflow. Codes 24 and 25 (greater or equal) are taken when the two flags are equal. Codes 26 and 27 (less or equal) are taken when zero = 1 or sign differs from overflow. Codes 28 and 29 (greater) are taken otherwise.
- R7: Every code in a synonym group gives the same `taken` for every flag combination.
- R8: Code 30 (count zero) is taken exactly when `count_in` is 0. It leaves `count_we` at 0 and `count_out` equal to `count_in`.
- R9: Code 31 (loop) drives `count_we` = 1 and `count_out` = `count_in` - 1 modulo 2^16. It is taken when that new value is nonzero. A count of 0 wraps to FFFFh and is taken. A count of 1 is not taken.
- R10: Codes 32 and 33 (loop while equal) are taken when the new count is nonzero and zero = 1. Codes 34 and 35 (loop while not equal) are taken when the new count is nonzero and zero = 0. All four codes decrement the count as in R9.
- R11: Code 36 (overflow trap) drives `trap_req` equal to the overflow flag, with `taken` = 0 and `count_we` = 0.
- R12: Codes 37 to 63 are undefined. They drive `taken`, `trap_req` and `count_we` to 0, with `count_out` equal to `count_in`.
- R13: Codes 0 to 30 never assert `count_we` or `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 6 | Operation code (see R1 to R12) |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag (1 = even parity of the low byte) |
| count_in | input | 16 | Current count register value |
| taken | output | 1 | Control transfer is taken |
| trap_req | output | 1 | Overflow trap request |
| count_out | output | 16 | Count value to write back |
| count_we | output | 1 | Write enable for `count_out` |

## Verification
Every flag-based code is applied under all 32 flag combinations. This separates carry-only tests from carry-or-zero tests, and signed tests built from sign and overflow from their zero-qualified variants. The same sweep compares each synonym against its group partners. Count-based codes are driven with counts of 0, 1, 2, FFFFh and a middle value, with the zero flag at both levels. These cases expose a missing wrap, a test done on the old count instead of the new one, and an inverted zero qualifier. The trap code, the undefined codes and the count-zero test are checked for stray write enables and for changes to the count.

// File: rtl/bcond_pkg.sv
package bcond_pkg;
  localparam int SEL_W = 6;

  typedef enum logic [2:0] {
    K_NONE, K_FLAG, K_CXZ, K_LOOP, K_TRAP
  } kind_e;

  typedef enum logic [2:0] {
    B_OVF, B_CARRY, B_ZERO, B_CARRY_OR_ZERO,
    B_SIGN, B_PARITY, B_SIGN_NE_OVF, B_LESS_EQ
  } base_e;

  typedef enum logic [1:0] {
    LZ_ANY, LZ_SET, LZ_CLEAR
  } loopz_e;

  typedef struct packed {
    kind_e  kind;
    base_e  base;
    logic   inv;
    loopz_e lz;
  } cond_t;
endpackage

// File: rtl/bcond_decode.sv
module bcond_decode
  import bcond_pkg::*;
(
  input  logic [SEL_W-1:0] op_sel,
  output cond_t            cond
);
  always_comb begin
    cond = '{kind: K_NONE, base: B_OVF, inv: 1'b0, lz: LZ_ANY};
    case (op_sel)
      6'd0:                cond = '{K_FLAG, B_OVF,           1'b0, LZ_ANY};
      6'd1:                cond = '{K_FLAG, B_OVF,           1'b1, LZ_ANY};
      6'd2, 6'd3, 6'd4:    cond = '{K_FLAG, B_CARRY,         1'b0, LZ_ANY};
      6'd5, 6'd6, 6'd7:    cond = '{K_FLAG, B_CARRY,         1'b1, LZ_ANY};
      6'd8, 6'd9:          cond = '{K_FLAG, B_ZERO,          1'b0, LZ_ANY};
      6'd10, 6'd11:        cond = '{K_FLAG, B_ZERO,          1'b1, LZ_ANY};
      6'd12, 6'd13:        cond = '{K_FLAG, B_CARRY_OR_ZERO, 1'b0, LZ_ANY};
      6'd14, 6'd15:        cond = '{K_FLAG, B_CARRY_OR_ZERO, 1'b1, LZ_ANY};
      6'd16:               cond = '{K_FLAG, B_SIGN,          1'b0, LZ_ANY};
      6'd17:               cond = '{K_FLAG, B_SIGN,          1'b1, LZ_ANY};
      6'd18, 6'd19:        cond = '{K_FLAG, B_PARITY,        1'b0, LZ_ANY};
      6'd20, 6'd21:        cond = '{K_FLAG, B_PARITY,        1'b1, LZ_ANY};
      6'd22, 6'd23:        cond = '{K_FLAG, B_SIGN_NE_OVF,   1'b0, LZ_ANY};
      6'd24, 6'd25:        cond = '{K_FLAG, B_SIGN_NE_OVF,   1'b1, LZ_ANY};
      6'd26, 6'd27:        cond = '{K_FLAG, B_LESS_EQ,       1'b0, LZ_ANY};
      6'd28, 6'd29:        cond = '{K_FLAG, B_LESS_EQ,       1'b1, LZ_ANY};
      6'd30:               cond = '{K_CXZ,  B_OVF,           1'b0, LZ_ANY};
      6'd31:               cond = '{K_LOOP, B_OVF,           1'b0, LZ_ANY};
      6'd32, 6'd33:        cond = '{K_LOOP, B_OVF,           1'b0, LZ_SET};
      6'd34, 6'd35:        cond = '{K_LOOP, B_OVF,           1'b0, LZ_CLEAR};
      6'd36:               cond = '{K_TRAP, B_OVF,           1'b0, LZ_ANY};
      default:             cond = '{K_NONE, B_OVF,           1'b0, LZ_ANY};
    endcase
  end

  // loop qualifier is only meaningful for loop-class operations (R10)
  always_comb begin
    p_lz_only_loop_r10: assert (cond.lz == LZ_ANY || cond.kind == K_LOOP)
      else $error("zero qualifier on non-loop code");
  end
endmodule

// File: rtl/bcond_flag_eval.sv
module bcond_flag_eval
  import bcond_pkg::*;
(
  input  base_e base,
  input  logic  inv,
  input  logic  cf,
  input  logic  zf,
  input  logic  sf,
  input  logic  of_f,
  input  logic  pf,
  output logic  hit
);
  logic raw;
  logic sign_ne_ovf;

  assign sign_ne_ovf = sf ^ of_f;

  always_comb begin
    case (base)
      B_OVF:           raw = of_f;
      B_CARRY:         raw = cf;
      B_ZERO:          raw = zf;
      B_CARRY_OR_ZERO: raw = cf | zf;
      B_SIGN:          raw = sf;
      B_PARITY:        raw = pf;
      B_SIGN_NE_OVF:   raw = sign_ne_ovf;
      B_LESS_EQ:       raw = zf | sign_ne_ovf;
      default:         raw = 1'b0;
    endcase
  end

  assign hit = raw ^ inv;

  // a set zero flag always satisfies a less-or-equal class test (R6)
  always_comb begin
    p_le_on_zero_r6: assert (!(base == B_LESS_EQ && !inv && zf) || hit)
      else $error("less-or-equal missed with zero set");
  end
endmodule

// File: rtl/bcond_count.sv
module bcond_count #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             cnt_is_zero,
  output logic             dec_nonzero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cnt_dec     = cnt - ONE;
  assign cnt_is_zero = (cnt == '0);
  assign dec_nonzero = (cnt != ONE);

  // a zero count wraps to all ones, which is nonzero (R9)
  always_comb begin
    p_wrap_r9: assert (!cnt_is_zero || (dec_nonzero && (&cnt_dec)))
      else $error("count wrap wrong");
  end
endmodule

// File: rtl/bcond_eval.sv
module bcond_eval
  import bcond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [5:0]       op_sel,
  input  logic             flag_cf,
  input  logic             flag_zf,
  input  logic             flag_sf,
  input  logic             flag_of,
  input  logic             flag_pf,
  input  logic [CNT_W-1:0] count_in,
  output logic             taken,
  output logic             trap_req,
  output logic [CNT_W-1:0] count_out,
  output logic             count_we
);
  cond_t            cond;
  logic             flag_hit;
  logic [CNT_W-1:0] cnt_dec;
  logic             cnt_is_zero;
  logic             dec_nonzero;
  logic             zf_ok;
  logic             is_loop;

  bcond_decode u_dec (
    .op_sel (op_sel),
    .cond   (cond)
  );

  bcond_flag_eval u_flag (
    .base (cond.base),
    .inv  (cond.inv),
    .cf   (flag_cf),
    .zf   (flag_zf),
    .sf   (flag_sf),
    .of_f (flag_of),
    .pf   (flag_pf),
    .hit  (flag_hit)
  );

  bcond_count #(.CNT_W(CNT_W)) u_cnt (
    .cnt         (count_in),
    .cnt_dec     (cnt_dec),
    .cnt_is_zero (cnt_is_zero),
    .dec_nonzero (dec_nonzero)
  );

  always_comb begin
    case (cond.lz)
      LZ_SET:   zf_ok = flag_zf;
      LZ_CLEAR: zf_ok = !flag_zf;
      default:  zf_ok = 1'b1;
    endcase
  end

  assign is_loop = (cond.kind == K_LOOP);

  always_comb begin
    case (cond.kind)
      K_FLAG:  taken = flag_hit;
      K_CXZ:   taken = cnt_is_zero;
      K_LOOP:  taken = dec_nonzero & zf_ok;
      default: taken = 1'b0;
    endcase
  end

  assign trap_req  = (cond.kind == K_TRAP) & flag_of;
  assign count_we  = is_loop;
  assign count_out = is_loop ? cnt_dec : count_in;

  always_comb begin
    p_trap_quiet_r11: assert (!trap_req || (!taken && !count_we && flag_of))
      else $error("trap request with side effects");
    p_loop_nonzero_r9: assert (!(taken && count_we) || (count_out != '0))
      else $error("loop taken on zero count");
    p_hold_count_r12: assert (count_we || (count_out == count_in))
      else $error("count changed without write");
    p_flag_codes_r13: assert (op_sel > 6'd30 || (!count_we && !trap_req))
      else $error("flag code touched count or trap");
  end
endmodule

// File: tb/bcond_eval_test.sv
module bcond_eval_test;
  logic        clk = 1'b0;
  logic [5:0]  op_sel = '0;
  logic        cf = 0, zf = 0, sf = 0, of_f = 0, pf = 0;
  logic [15:0] count_in = '0;
  logic        taken, trap_req, count_we;
  logic [15:0] count_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcond_eval uut (
    .op_sel(op_sel), .flag_cf(cf), .flag_zf(zf), .flag_sf(sf),
    .flag_of(of_f), .flag_pf(pf), .count_in(count_in),
    .taken(taken), .trap_req(trap_req), .count_out(count_out),
    .count_we(count_we)
  );

  function automatic string req_of(input int c);
    if (c <= 1) return "R1";
    if (c <= 7) return "R2";
    if (c <= 11) return "R3";
    if (c <= 15) return "R4";
    if (c <= 21) return "R5";
    return "R6";
  endfunction

  // expected flag-based outcome, from the requirement text
  function automatic bit exp_flag(input int c, input bit c_f, z_f, s_f, o_f, p_f);
    case (c)
      0: return o_f;              1: return !o_f;
      2, 3, 4: return c_f;        5, 6, 7: return !c_f;
      8, 9: return z_f;           10, 11: return !z_f;
      12, 13: return c_f | z_f;   14, 15: return !(c_f | z_f);
      16: return s_f;             17: return !s_f;
      18, 19: return p_f;         20, 21: return !p_f;
      22, 23: return s_f != o_f;  24, 25: return s_f == o_f;
      26, 27: return z_f | (s_f != o_f);
      default: return !(z_f | (s_f != o_f));
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int c, input logic [4:0] f, input logic [15:0] cnt);
    @(negedge clk);
    op_sel = 6'(c);
    {cf, zf, sf, of_f, pf} = f;
    count_in = cnt;
    #1;
  endtask

  task automatic t_reset_state();
    apply(0, 5'b0, 16'h0);
    chk("R1", "idle taken", 16'(taken), 16'h0);
    chk("R13", "idle we", 16'(count_we), 16'h0);
    chk("R13", "idle trap", 16'(trap_req), 16'h0);
  endtask

  task automatic t_flag_codes();
    for (int c = 0; c <= 29; c++)
      for (int f = 0; f < 32; f++) begin
        logic [4:0] fv = 5'(f);
        apply(c, fv, 16'h1234);
        chk(req_of(c), $sformatf("code %0d flags %b", c, fv), 16'(taken),
            16'(exp_flag(c, fv[4], fv[3], fv[2], fv[1], fv[0])));
        chk("R13", "no write", 16'(count_we), 16'h0);
        chk("R13", "no trap", 16'(trap_req), 16'h0);
      end
  endtask

  task automatic t_synonyms();
    int grp [10][3] = '{'{2,3,4}, '{5,6,7}, '{8,9,9}, '{10,11,11}, '{12,13,13},
                        '{14,15,15}, '{18,19,19}, '{20,21,21}, '{22,23,23}, '{28,29,29}};
    for (int g = 0; g < 10; g++)
      for (int f = 0; f < 32; f++) begin
        logic ref_t;
        apply(grp[g][0], 5'(f), 16'h5);
        ref_t = taken;
        for (int m = 1; m < 3; m++) begin
          apply(grp[g][m], 5'(f), 16'h5);
          chk("R7", $sformatf("code %0d vs %0d", grp[g][m], grp[g][0]), 16'(taken), 16'(ref_t));
        end
      end
  endtask

  task automatic t_count_zero();
    logic [15:0] vals [4] = '{16'h0, 16'h1, 16'h8000, 16'hFFFF};
    for (int i = 0; i < 4; i++) begin
      apply(30, 5'b01000, vals[i]);
      chk("R8", "taken", 16'(taken), 16'(vals[i] == 0));
      chk("R8", "we", 16'(count_we), 16'h0);
      chk("R8", "count", count_out, vals[i]);
    end
  endtask

  task automatic t_loop();
    logic [15:0] vals [5] = '{16'h0, 16'h1, 16'h2, 16'hFFFF, 16'h0400};
    for (int i = 0; i < 5; i++) begin
      logic [15:0] nv = vals[i] - 16'h1;
      apply(31, 5'b00000, vals[i]);
      chk("R9", "we", 16'(count_we), 16'h1);
      chk("R9", "count", count_out, nv);
      chk("R9", "taken", 16'(taken), 16'(nv != 0));
    end
  endtask

  task automatic t_loop_zf();
    logic [15:0] vals [4] = '{16'h0, 16'h1, 16'h2, 16'h0033};
    for (int c = 32; c <= 35; c++)
      for (int i = 0; i < 4; i++)
        for (int z = 0; z < 2; z++) begin
          logic [15:0] nv = vals[i] - 16'h1;
          bit want = (nv != 0) && ((c <= 33) ? (z == 1) : (z == 0));
          apply(c, {1'b0, 1'(z), 3'b000}, vals[i]);
          chk("R10", $sformatf("code %0d cnt %h zf %0d taken", c, vals[i], z), 16'(taken), 16'(want));
          chk("R10", "count", count_out, nv);
          chk("R10", "we", 16'(count_we), 16'h1);
        end
  endtask

  task automatic t_trap();
    for (int o = 0; o < 2; o++) begin
      apply(36, {3'b111, 1'(o), 1'b1}, 16'h0007);
      chk("R11", "trap", 16'(trap_req), 16'(o));
      chk("R11", "taken", 16'(taken), 16'h0);
      chk("R11", "we", 16'(count_we), 16'h0);
      chk("R11", "count", count_out, 16'h0007);
    end
  endtask

  task automatic t_undefined();
    for (int c = 37; c <= 63; c++) begin
      apply(c, 5'b11111, 16'h0000);
      chk("R12", $sformatf("code %0d taken", c), 16'(taken), 16'h0);
      chk("R12", "trap", 16'(trap_req), 16'h0);
      chk("R12", "we", 16'(count_we), 16'h0);
      chk("R12", "count", count_out, 16'h0000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_flag_codes();
    t_synonyms();
    t_count_zero();
    t_loop();
    t_loop_zf();
    t_trap();
    t_undefined();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule